// File: doc/BRIEF.md
# I2C Target Register Port for a Clock Peripheral

This block is the serial front end of a small timekeeping peripheral. It watches an I2C bus and answers only to the 7-bit target address 68h, which appears on the wire as D0h for writes and D1h for reads. The core owns the storage. This block presents a 20-location, 8-bit register space through a parallel port: a location index, a write strobe with write data, and a read data return.

In a write transfer, the first byte after the address selects a location. Each further byte is written there, and then the location index moves on by one. A read transfer sends data from the current location and advances the index after every byte, so the usual pattern is a pointer write, a repeated START and a read. The index steps from the last location back to the first. Bits that a location does not implement read as zero and are never written. A test bit in location 00h is always written as zero. When the block accepts a read address, it sends the core a one-cycle strobe so the core can freeze its counters for a consistent snapshot.

Top module: `rtc_i2c_regif`

## Requirements
- R1: While reset is high and after it is released, sda_oe, reg_we and rd_start are 0 and reg_addr is 00h.
- R2: An address byte of D0h or D1h (target 68h) is acknowledged: SDA is held low during the ninth clock.
- R3: An address byte for any other target is not acknowledged. Every byte after it is ignored until the next START: no acknowledge and no reg_we.
- R4: The first byte after D0h is acknowledged and, when it is below 20 (14h), becomes the location index.
- R5: A location byte of 14h or more is not acknowledged and leaves the location index unchanged.
- R6: Each later byte of a write transfer produces exactly one single-cycle reg_we, with reg_addr at the current index. The index then advances by one.
- R7: The index advances from 13h to 00h, on reads and on writes, and never holds a value of 20 or more.
- R8: After D1h, bytes are sent MSB first starting at the current index, and the index advances after every byte. After the master's NACK the target releases SDA.
- R9: rd_start pulses high for exactly one cycle each time a read address is acknowledged, and not on write transfers.
- R10: Read data is reg_rdata ANDed with a per-location mask. The mask is FFh for 00h, 01h, 03h, 09h, 0Ah, 0Eh, 0Fh, 11h and 13h; 7Fh for 04h; 3Fh for 05h and 06h; 07h for 07h and 10h; 1Fh for 08h; EFh for 02h; BFh for 0Bh and 0Ch; 87h for 0Dh; and 77h for 12h.
- R11: reg_wdata is the received byte ANDed with the same mask, except that location 00h uses BFh so its bit 6 is always written as 0.
- R12: sda_oe changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain drive) |
| reg_addr | output | 5 | Current location index toward the core |
| reg_wdata | output | 8 | Masked write data |
| reg_we | output | 1 | Single-cycle write strobe |
| reg_rdata | input | 8 | Core data for reg_addr, valid one cycle after reg_addr |
| rd_start | output | 1 | One-cycle pulse when a read transfer starts |

## Verification
The checker assumes the master keeps SCL low for longer than the synchronizer delay plus one cycle. It also assumes the master never issues START or STOP while the target is pulling SDA low, so every change of sda_oe falls inside an SCL low phase. It further assumes reg_rdata follows reg_addr within one cycle. The bench master holds each SCL phase for 16 system clocks and changes SDA only at the middle of the low phase, except for its deliberate START and STOP edges. Its core model is a one-cycle-latency memory.

// File: rtl/rtc_i2c_pkg.sv
package rtc_i2c_pkg;
  localparam int DATA_W  = 8;
  localparam int NUM_LOC = 20;
  localparam int PTR_W   = $clog2(NUM_LOC);
  localparam logic [6:0] DEV_ID = 7'h68;
  localparam int TEST_LOC = 0;
  localparam int TEST_BIT = 6;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RX_ACK,
    ST_TX,
    ST_TX_ACK
  } bus_state_e;

  typedef enum logic [1:0] {
    K_ADDR,
    K_PTR,
    K_DATA
  } rx_kind_e;

  // implemented bits per location
  function automatic logic [DATA_W-1:0] read_mask(input logic [PTR_W-1:0] loc);
    logic [DATA_W-1:0] m;
    case (loc)
      5'h02:               m = 8'hEF;
      5'h04:               m = 8'h7F;
      5'h05, 5'h06:        m = 8'h3F;
      5'h07, 5'h10:        m = 8'h07;
      5'h08:               m = 8'h1F;
      5'h0B, 5'h0C:        m = 8'hBF;
      5'h0D:               m = 8'h87;
      5'h12:               m = 8'h77;
      5'h00, 5'h01, 5'h03, 5'h09, 5'h0A,
      5'h0E, 5'h0F, 5'h11, 5'h13: m = 8'hFF;
      default:             m = 8'h00;
    endcase
    return m;
  endfunction

  function automatic logic [DATA_W-1:0] write_mask(input logic [PTR_W-1:0] loc);
    logic [DATA_W-1:0] m;
    m = read_mask(loc);
    if (loc == PTR_W'(TEST_LOC)) m[TEST_BIT] = 1'b0;
    return m;
  endfunction
endpackage

// File: rtl/rtc_i2c_sync.sv
module rtc_i2c_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic lvl,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '1;
      prev  <= 1'b1;
    end else begin
      chain <= {chain[STAGES-2:0], din};
      prev  <= chain[STAGES-1];
    end
  end

  assign lvl  = chain[STAGES-1];
  assign rise = chain[STAGES-1] & ~prev;
  assign fall = ~chain[STAGES-1] & prev;
endmodule

// File: rtl/rtc_i2c_mask.sv
module rtc_i2c_mask
  import rtc_i2c_pkg::*;
#(
  parameter int PW = PTR_W,
  parameter int DW = DATA_W
) (
  input  logic [PW-1:0] loc,
  input  logic [DW-1:0] rd_raw,
  input  logic [DW-1:0] wr_raw,
  output logic [DW-1:0] rd_masked,
  output logic [DW-1:0] wr_masked
);
  always_comb begin
    rd_masked = rd_raw & read_mask(loc);
    wr_masked = wr_raw & write_mask(loc);
  end
endmodule

// File: rtl/rtc_i2c_ctrl.sv
module rtc_i2c_ctrl
  import rtc_i2c_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = DEV_ID,
  parameter int N_LOC = NUM_LOC,
  parameter int PW    = PTR_W,
  parameter int DW    = DATA_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          sda_lvl,
  input  logic          bus_start,
  input  logic          bus_stop,
  input  logic [DW-1:0] rd_masked,
  input  logic [DW-1:0] wr_masked,
  output logic [PW-1:0] ptr,
  output logic [DW-1:0] rx_byte,
  output logic          sda_oe,
  output logic          we,
  output logic [DW-1:0] wdata,
  output logic          rd_begin
);
  localparam int CNT_W = $clog2(DW + 1);
  localparam logic [CNT_W-1:0] BYTE_END = CNT_W'(DW);
  localparam logic [PW-1:0]    LAST_LOC = PW'(N_LOC - 1);

  bus_state_e       st;
  rx_kind_e         kind;
  logic [CNT_W-1:0] cnt;
  logic [DW-1:0]    sh;
  logic             acked;
  logic             rd_mode;
  logic             m_ack;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == LAST_LOC) ? '0 : p + 1'b1;
  endfunction

  assign rx_byte = sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      kind     <= K_ADDR;
      cnt      <= '0;
      sh       <= '0;
      acked    <= 1'b0;
      rd_mode  <= 1'b0;
      m_ack    <= 1'b0;
      ptr      <= '0;
      sda_oe   <= 1'b0;
      we       <= 1'b0;
      wdata    <= '0;
      rd_begin <= 1'b0;
    end else begin
      we       <= 1'b0;
      rd_begin <= 1'b0;
      if (bus_start) begin
        st     <= ST_RX;
        kind   <= K_ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (bus_stop) begin
        st     <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (st)
          ST_RX: begin
            if (scl_rise && cnt != BYTE_END) begin
              sh  <= {sh[DW-2:0], sda_lvl};
              cnt <= cnt + 1'b1;
            end else if (scl_fall && cnt == BYTE_END) begin
              cnt <= '0;
              st  <= ST_RX_ACK;
              case (kind)
                K_ADDR: begin
                  if (sh[DW-1 -: 7] == DEV_ADDR) begin
                    acked    <= 1'b1;
                    sda_oe   <= 1'b1;
                    rd_mode  <= sh[0];
                    rd_begin <= sh[0];
                  end else begin
                    st <= ST_IDLE;
                  end
                end
                K_PTR: begin
                  if (sh < DW'(N_LOC)) begin
                    ptr    <= sh[PW-1:0];
                    acked  <= 1'b1;
                    sda_oe <= 1'b1;
                  end else begin
                    acked <= 1'b0;
                  end
                end
                default: begin
                  we     <= 1'b1;
                  wdata  <= wr_masked;
                  acked  <= 1'b1;
                  sda_oe <= 1'b1;
                end
              endcase
            end
          end
          ST_RX_ACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              cnt    <= '0;
              if (!acked) begin
                st <= ST_IDLE;
              end else if (kind == K_ADDR && rd_mode) begin
                st     <= ST_TX;
                sh     <= rd_masked;
                sda_oe <= ~rd_masked[DW-1];
              end else begin
                st <= ST_RX;
                if (kind == K_ADDR) kind <= K_PTR;
                else if (kind == K_PTR) kind <= K_DATA;
                else ptr <= step(ptr);
              end
            end
          end
          ST_TX: begin
            if (scl_rise) begin
              cnt <= cnt + 1'b1;
            end else if (scl_fall) begin
              if (cnt == BYTE_END) begin
                sda_oe <= 1'b0;
                st     <= ST_TX_ACK;
                ptr    <= step(ptr);
              end else begin
                sh     <= {sh[DW-2:0], 1'b0};
                sda_oe <= ~sh[DW-2];
              end
            end
          end
          ST_TX_ACK: begin
            if (scl_rise) begin
              m_ack <= ~sda_lvl;
            end else if (scl_fall) begin
              cnt <= '0;
              if (m_ack) begin
                st     <= ST_TX;
                sh     <= rd_masked;
                sda_oe <= ~rd_masked[DW-1];
              end else begin
                st <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/rtc_i2c_regif.sv
module rtc_i2c_regif
  import rtc_i2c_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = DEV_ID,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic [PTR_W-1:0]  reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              reg_we,
  input  logic [DATA_W-1:0] reg_rdata,
  output logic              rd_start
);
  logic scl_lvl, scl_rise, scl_fall;
  logic sda_lvl, sda_rise, sda_fall;
  logic bus_start, bus_stop;
  logic [DATA_W-1:0] rx_byte, rd_masked, wr_masked;

  rtc_i2c_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
    .clk(clk), .rst(rst), .din(scl_i),
    .lvl(scl_lvl), .rise(scl_rise), .fall(scl_fall)
  );

  rtc_i2c_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
    .clk(clk), .rst(rst), .din(sda_i),
    .lvl(sda_lvl), .rise(sda_rise), .fall(sda_fall)
  );

  assign bus_start = sda_fall & scl_lvl;
  assign bus_stop  = sda_rise & scl_lvl;

  rtc_i2c_mask #(.PW(PTR_W), .DW(DATA_W)) u_mask (
    .loc(reg_addr), .rd_raw(reg_rdata), .wr_raw(rx_byte),
    .rd_masked(rd_masked), .wr_masked(wr_masked)
  );

  rtc_i2c_ctrl #(
    .DEV_ADDR(DEV_ADDR), .N_LOC(NUM_LOC), .PW(PTR_W), .DW(DATA_W)
  ) u_ctrl (
    .clk(clk), .rst(rst),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_lvl(sda_lvl),
    .bus_start(bus_start), .bus_stop(bus_stop),
    .rd_masked(rd_masked), .wr_masked(wr_masked),
    .ptr(reg_addr), .rx_byte(rx_byte), .sda_oe(sda_oe),
    .we(reg_we), .wdata(reg_wdata), .rd_begin(rd_start)
  );
endmodule

// File: rtl/rtc_i2c_regif_chk.sv
module rtc_i2c_regif_chk
  import rtc_i2c_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              scl_i,
  input logic              sda_oe,
  input logic [PTR_W-1:0]  reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic              reg_we,
  input logic              rd_start
);
  // R6: write strobe lasts a single cycle
  p_we_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    reg_we |=> !reg_we);

  // R7: location index stays inside the register space
  p_ptr_range_r7: assert property (@(posedge clk) disable iff (rst)
    reg_addr < PTR_W'(NUM_LOC));

  // R11: test bit of location 00h is never written as 1
  p_test_bit_r11: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_addr == '0) |-> !reg_wdata[TEST_BIT]);

  // R9: read strobe is a one-cycle pulse
  p_rd_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    rd_start |=> !rd_start);

  // R12: data drive changes only in the clock-low phase
  p_oe_scl_low_r12: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe) |-> !scl_i);
endmodule

bind rtc_i2c_regif rtc_i2c_regif_chk u_chk (
  .clk(clk), .rst(rst), .scl_i(scl_i), .sda_oe(sda_oe),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
  .rd_start(rd_start)
);

// File: tb/rtc_i2c_regif_tb_top.sv
module rtc_i2c_regif_tb_top;
  localparam int Q = 8;
  localparam logic [7:0] WR_ADDR = 8'hD0;
  localparam logic [7:0] RD_ADDR = 8'hD1;
  // {location, byte written, expected readback}
  localparam logic [23:0] VEC [10] = '{
    24'h00FFBF, 24'h02FFEF, 24'h04FF7F, 24'h07FF07, 24'h0DFF87,
    24'h12FF77, 24'h08A505, 24'h0B5A1A, 24'h133C3C, 24'h05C303
  };

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst = 1'b1;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, reg_we, rd_start;
  logic [4:0] reg_addr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  wire scl_line = scl_m;
  wire sda_line = sda_m & ~sda_oe;

  rtc_i2c_regif dut_i (
    .clk(clk), .rst(rst), .scl_i(scl_line), .sda_i(sda_line),
    .sda_oe(sda_oe), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_rdata(reg_rdata), .rd_start(rd_start)
  );

  // core model: one-cycle read latency
  logic [7:0] mem [20];
  logic       preload = 1'b0;
  always @(posedge clk) begin
    if (preload) begin
      for (int i = 0; i < 20; i++) mem[i] <= 8'hFF;
    end else if (reg_we && reg_addr < 5'd20) begin
      mem[reg_addr] <= reg_wdata;
    end
    reg_rdata <= (reg_addr < 5'd20) ? mem[reg_addr] : 8'h00;
  end

  int we_cnt = 0, rd_cnt = 0, oe_viol = 0;
  logic [4:0] we_addr_log [64];
  logic [7:0] we_data_log [64];
  logic oe_q = 1'b0;
  always @(posedge clk) begin
    if (reg_we) begin
      we_addr_log[we_cnt % 64] <= reg_addr;
      we_data_log[we_cnt % 64] <= reg_wdata;
      we_cnt <= we_cnt + 1;
    end
    if (rd_start) rd_cnt <= rd_cnt + 1;
    oe_q <= sda_oe;
    if (!rst && sda_oe != oe_q && scl_line) oe_viol <= oe_viol + 1;
  end

  int total = 0, fails = 0;
  logic [7:0] rbuf [32];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] rm(input int a);
    case (a)
      2: return 8'hEF;
      4: return 8'h7F;
      5, 6: return 8'h3F;
      7, 16: return 8'h07;
      8: return 8'h1F;
      11, 12: return 8'hBF;
      13: return 8'h87;
      18: return 8'h77;
      default: return 8'hFF;
    endcase
  endfunction

  task automatic wq(); repeat (Q) @(negedge clk); endtask
  task automatic bus_start(); sda_m = 1; wq(); scl_m = 1; wq(); sda_m = 0; wq(); scl_m = 0; wq(); endtask
  task automatic bus_stop(); sda_m = 0; wq(); scl_m = 1; wq(); sda_m = 1; wq(); endtask
  task automatic put_bit(input logic b); sda_m = b; wq(); scl_m = 1; wq(); wq(); scl_m = 0; wq(); endtask
  task automatic get_bit(output logic b); sda_m = 1; wq(); scl_m = 1; wq(); b = sda_line; wq(); scl_m = 0; wq(); endtask

  task automatic put_byte(input logic [7:0] d, output logic acked);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(b);
    acked = !b;
  endtask

  task automatic get_byte(input logic ack, output logic [7:0] d);
    logic b;
    for (int i = 7; i >= 0; i--) begin get_bit(b); d[i] = b; end
    put_bit(!ack);
  endtask

  task automatic write_at(input logic [7:0] p, input logic [7:0] d);
    logic a;
    bus_start();
    put_byte(WR_ADDR, a); chk("R2 write address ack", a, 1);
    put_byte(p, a);       chk("R4 location ack", a, 1);
    put_byte(d, a);       chk("R6 data ack", a, 1);
    bus_stop();
  endtask

  task automatic read_from(input logic [7:0] p, input int n);
    logic a;
    logic [7:0] d;
    bus_start();
    put_byte(WR_ADDR, a); chk("R2 write address ack", a, 1);
    put_byte(p, a);       chk("R4 location ack", a, 1);
    bus_start();
    put_byte(RD_ADDR, a); chk("R2 read address ack", a, 1);
    for (int i = 0; i < n; i++) begin
      get_byte(i != n - 1, d);
      rbuf[i] = d;
    end
    chk("R8 SDA released after NACK", sda_oe, 0);
    bus_stop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic a;
    logic [7:0] d;
    int base, rbase;
    repeat (4) @(negedge clk);
    chk("R1 sda_oe in reset", sda_oe, 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 sda_oe after reset", sda_oe, 0);
    chk("R1 reg_we after reset", reg_we, 0);
    chk("R1 rd_start after reset", rd_start, 0);
    chk("R1 reg_addr after reset", reg_addr, 0);

    // table walk: write then read back, R10 and R11 masks
    for (int v = 0; v < 10; v++) begin
      write_at(VEC[v][23:16], VEC[v][15:8]);
      read_from(VEC[v][23:16], 1);
      chk("R11 masked write readback", rbuf[0], VEC[v][7:0]);
    end

    // R7/R10: sequential read across the wrap with all bits set
    preload = 1'b1; @(negedge clk); preload = 1'b0;
    base = we_cnt; rbase = rd_cnt;
    read_from(8'h12, 22);
    for (int i = 0; i < 22; i++)
      chk("R7 R10 wrapped read", rbuf[i], rm((18 + i) % 20));
    chk("R9 one rd_start per read", rd_cnt - rbase, 1);
    chk("R8 read makes no write", we_cnt - base, 0);

    // R3: foreign address
    base = we_cnt;
    bus_start();
    put_byte(8'hA0, a); chk("R3 foreign address NACK", a, 0);
    put_byte(8'h00, a); chk("R3 following byte NACK", a, 0);
    put_byte(8'h55, a); chk("R3 second byte NACK", a, 0);
    bus_stop();
    chk("R3 no write strobe", we_cnt - base, 0);

    // R4/R8: load index only, then read from current index
    write_at(8'h03, 8'h42);
    bus_start();
    put_byte(WR_ADDR, a); put_byte(8'h03, a); chk("R4 index-only ack", a, 1);
    bus_stop();
    rbase = rd_cnt;
    bus_start();
    put_byte(RD_ADDR, a); chk("R2 direct read ack", a, 1);
    get_byte(1'b1, d); chk("R4 data at loaded index", d, 8'h42);
    get_byte(1'b0, d); chk("R8 index advanced on read", d, 8'h7F);
    chk("R8 SDA released after NACK", sda_oe, 0);
    bus_stop();
    chk("R9 rd_start on direct read", rd_cnt - rbase, 1);

    // R5: out-of-range index is refused and index kept
    bus_start();
    put_byte(WR_ADDR, a); put_byte(8'h03, a);
    bus_stop();
    bus_start();
    put_byte(WR_ADDR, a);
    put_byte(8'h14, a); chk("R5 index 14h NACK", a, 0);
    bus_stop();
    bus_start();
    put_byte(RD_ADDR, a);
    get_byte(1'b0, d); chk("R5 index unchanged", d, 8'h42);
    bus_stop();

    // R6/R7: multi-byte write across the wrap
    base = we_cnt; rbase = rd_cnt;
    bus_start();
    put_byte(WR_ADDR, a); put_byte(8'h13, a);
    put_byte(8'h11, a); put_byte(8'hE2, a); put_byte(8'h33, a);
    bus_stop();
    chk("R6 one strobe per byte", we_cnt - base, 3);
    chk("R6 first write location", we_addr_log[base % 64], 5'h13);
    chk("R6 first write data", we_data_log[base % 64], 8'h11);
    chk("R7 wrapped write location", we_addr_log[(base + 1) % 64], 5'h00);
    chk("R11 test bit forced low", we_data_log[(base + 1) % 64], 8'hA2);
    chk("R7 location after wrap", we_addr_log[(base + 2) % 64], 5'h01);
    chk("R9 no rd_start on write", rd_cnt - rbase, 0);

    chk("R12 drive changes only with SCL low", oe_viol, 0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule